// File: doc/BRIEF.md
# UART Auto-Baud Rate Detector

This block watches an idle-high asynchronous serial receive line and works out the link's bit rate with no help from software. Once armed, it treats the first low pulse on the line as a start bit. It counts how many system clock cycles that pulse lasts and compares the count with a fixed table of standard bit rates. If the count falls inside the tolerance window of one entry, the block reports that entry's nominal bit-period divisor and its index and raises a lock flag. A separate UART receiver then uses the divisor to time its bit sampling.

A single noise glitch must not set a wrong rate, so a pulse that fits no table entry is discarded and the detector waits for the next falling edge. A low period longer than the slowest entry allows is a break or a stuck line, and the block reports it as an error. After a lock or an error the detector ignores the line until a re-arm request arrives.

Top module: `uart_autobaud`

## Requirements
- R1: While reset is held and in the first cycle after it, locked_o, error_o and decided_o are 0, and divisor_o and rate_idx_o are 0.
- R2: The rate table has ten entries. Entry i (0..7) is 300·2^i bit/s, entry 8 is 57600 and entry 9 is 115200. The nominal period of an entry is P = CLK_HZ / rate. A measured low width W locks to entry i when |W − P| ≤ floor(P / TOL_DIV), with TOL_DIV = 50 (about ±2 %). W is the number of clock cycles for which the line was low.
- R3: On lock, divisor_o holds the matched entry's nominal period P and not the raw count, and rate_idx_o holds the entry index i.
- R4: A low pulse whose width matches no entry and does not exceed the error limit gives no lock, no error and no decided_o pulse. The detector re-arms at once, so the next low pulse is measured.
- R5: A low period longer than P0 + floor(P0 / TOL_DIV), where P0 is the period of entry 0, sets error_o and leaves locked_o at 0. A width exactly equal to that limit still locks to entry 0.
- R6: locked_o and error_o are never high together. decided_o is a one-cycle pulse, given exactly once, in the cycle that locked_o or error_o is first raised.
- R7: Once locked or in error, the detector ignores all further line activity. Outputs hold and decided_o stays low until rearm_i.
- R8: rearm_i clears locked_o and error_o on the next clock. The detector then accepts a falling edge only after the synchronized line has been seen high for at least one cycle, so a line that is already low during re-arm is not measured.
- R9: line_i passes through a two-stage synchronizer. The decision registers on the third rising clock edge after line_i is first sampled high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| rearm_i | input | 1 | Clear result and wait for a new start bit |
| line_i | input | 1 | Asynchronous serial line, idle high |
| divisor_o | output | CW | Matched nominal bit period in clock cycles |
| rate_idx_o | output | IW | Index of the matched rate table entry |
| locked_o | output | 1 | A rate has been matched |
| error_o | output | 1 | Over-long low period (break or stuck line) |
| decided_o | output | 1 | One-cycle strobe when lock or error is decided |

## Verification
On every cycle the assertions check that lock and error exclude each other and that the decision strobe is a single-cycle pulse that comes with one of them. They also check that a locked divisor always equals the table period for the reported index, that results hold steady until a re-arm, and that a re-arm clears both flags. Other behaviour shows only in the bench's scenarios: the tolerance boundaries of each entry, the rejection of unmatched pulses and the measurement of the pulse that follows, the error limit exactly and one past it, and the refusal to measure a line that is already low when the detector is re-armed.

// File: rtl/abd_pkg.sv
package abd_pkg;

  localparam int unsigned NUM_RATES = 10;

  typedef enum logic [2:0] {
    ST_WAIT_IDLE,
    ST_ARMED,
    ST_MEAS,
    ST_LOCKED,
    ST_FAULT
  } abd_state_e;

  // Standard rate for table entry i: a doubling series from 300, then two fast rates.
  function automatic int unsigned rate_of(int unsigned i);
    if (i < 8) return 300 << i;
    else if (i == 8) return 57600;
    else return 115200;
  endfunction

  // Nominal bit period in clock cycles.
  function automatic int unsigned period_of(int unsigned clk_hz, int unsigned i);
    return clk_hz / rate_of(i);
  endfunction

  // Allowed deviation around a nominal period.
  function automatic int unsigned slack_of(int unsigned p, int unsigned tol_div);
    return p / tol_div;
  endfunction

endpackage

// File: rtl/abd_sync.sv
module abd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i) begin
        if (rst_i) sh <= '1;
        else       sh <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i) begin
        if (rst_i) sh <= '1;
        else       sh <= {sh[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sh[STAGES-1];
endmodule

// File: rtl/abd_width_ctr.sv
module abd_width_ctr #(
  parameter int unsigned CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          start_i,
  input  logic          run_i,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_o <= '0;
    end else if (start_i) begin
      cnt_o <= CW'(1);
    end else if (run_i && (cnt_o != '1)) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/abd_rate_match.sv
module abd_rate_match #(
  parameter int unsigned CLK_HZ  = 50_000_000,
  parameter int unsigned TOL_DIV = 50,
  parameter int unsigned CW      = 18,
  parameter int unsigned IW      = 4
) (
  input  logic [CW-1:0] width_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o,
  output logic [CW-1:0] period_o
);
  localparam int unsigned N = abd_pkg::NUM_RATES;

  logic [N-1:0]  hit_v;
  logic [CW-1:0] per_v [N];

  generate
    for (genvar i = 0; i < N; i++) begin : g_entry
      localparam int unsigned P  = abd_pkg::period_of(CLK_HZ, i);
      localparam int unsigned S  = abd_pkg::slack_of(P, TOL_DIV);
      localparam logic [CW-1:0] LO = CW'(P - S);
      localparam logic [CW-1:0] HI = CW'(P + S);
      assign hit_v[i] = (width_i >= LO) && (width_i <= HI);
      assign per_v[i] = CW'(P);
    end
  endgenerate

  // Lowest matching index wins; windows do not overlap for the standard table.
  always_comb begin
    hit_o    = 1'b0;
    idx_o    = '0;
    period_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (hit_v[k]) begin
        hit_o    = 1'b1;
        idx_o    = IW'(k);
        period_o = per_v[k];
      end
    end
  end
endmodule

// File: rtl/uart_autobaud.sv
module uart_autobaud #(
  parameter int unsigned CLK_HZ  = 50_000_000,
  parameter int unsigned TOL_DIV = 50,
  localparam int unsigned SLOW_P = abd_pkg::period_of(CLK_HZ, 0),
  localparam int unsigned LIMIT  = SLOW_P + abd_pkg::slack_of(SLOW_P, TOL_DIV),
  localparam int unsigned CW     = $clog2(LIMIT + 2),
  localparam int unsigned IW     = $clog2(abd_pkg::NUM_RATES)
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          rearm_i,
  input  logic          line_i,
  output logic [CW-1:0] divisor_o,
  output logic [IW-1:0] rate_idx_o,
  output logic          locked_o,
  output logic          error_o,
  output logic          decided_o
);
  import abd_pkg::*;

  abd_state_e    state;
  logic          line_s;
  logic [CW-1:0] width;
  logic          hit;
  logic [IW-1:0] hit_idx;
  logic [CW-1:0] hit_period;

  // Named internal events
  logic fall_evt;
  logic rise_evt;
  logic low_run;
  logic too_long;

  abd_sync #(.STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (line_i),
    .q_o   (line_s)
  );

  assign fall_evt = (state == ST_ARMED) && !line_s;
  assign low_run  = (state == ST_MEAS) && !line_s;
  assign rise_evt = (state == ST_MEAS) && line_s;
  assign too_long = low_run && (width >= CW'(LIMIT));

  abd_width_ctr #(.CW(CW)) u_ctr (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .start_i (fall_evt),
    .run_i   (low_run),
    .cnt_o   (width)
  );

  abd_rate_match #(
    .CLK_HZ  (CLK_HZ),
    .TOL_DIV (TOL_DIV),
    .CW      (CW),
    .IW      (IW)
  ) u_match (
    .width_i  (width),
    .hit_o    (hit),
    .idx_o    (hit_idx),
    .period_o (hit_period)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state      <= ST_WAIT_IDLE;
      locked_o   <= 1'b0;
      error_o    <= 1'b0;
      decided_o  <= 1'b0;
      divisor_o  <= '0;
      rate_idx_o <= '0;
    end else begin
      decided_o <= 1'b0;
      if (rearm_i) begin
        state    <= ST_WAIT_IDLE;
        locked_o <= 1'b0;
        error_o  <= 1'b0;
      end else begin
        unique case (state)
          ST_WAIT_IDLE: if (line_s) state <= ST_ARMED;
          ST_ARMED:     if (fall_evt) state <= ST_MEAS;
          ST_MEAS: begin
            if (rise_evt) begin
              if (hit) begin
                locked_o   <= 1'b1;
                decided_o  <= 1'b1;
                divisor_o  <= hit_period;
                rate_idx_o <= hit_idx;
                state      <= ST_LOCKED;
              end else begin
                state <= ST_ARMED;
              end
            end else if (too_long) begin
              error_o   <= 1'b1;
              decided_o <= 1'b1;
              state     <= ST_FAULT;
            end
          end
          ST_LOCKED: state <= ST_LOCKED;
          ST_FAULT:  state <= ST_FAULT;
          default:   state <= ST_WAIT_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_autobaud_chk.sv
module uart_autobaud_chk #(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned CW     = 18,
  parameter int unsigned IW     = 4
) (
  input logic          clk_i,
  input logic          rst_i,
  input logic          rearm_i,
  input logic [CW-1:0] divisor_o,
  input logic [IW-1:0] rate_idx_o,
  input logic          locked_o,
  input logic          error_o,
  input logic          decided_o
);
  // R6
  excl_flags_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !(locked_o && error_o));

  // R6
  strobe_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    decided_o |=> !decided_o);

  // R6
  strobe_cause_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    decided_o |-> (locked_o || error_o));

  // R3
  div_table_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    locked_o |-> (divisor_o == CW'(abd_pkg::period_of(CLK_HZ, 32'(rate_idx_o)))));

  // R7
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (locked_o && !rearm_i) |=> (locked_o && $stable(divisor_o) && $stable(rate_idx_o) && !decided_o));

  // R7
  err_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (error_o && !rearm_i) |=> (error_o && !decided_o));

  // R8
  rearm_clr_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    rearm_i |=> (!locked_o && !error_o && !decided_o));
endmodule

bind uart_autobaud uart_autobaud_chk #(
  .CLK_HZ (CLK_HZ),
  .CW     (CW),
  .IW     (IW)
) u_chk (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .rearm_i    (rearm_i),
  .divisor_o  (divisor_o),
  .rate_idx_o (rate_idx_o),
  .locked_o   (locked_o),
  .error_o    (error_o),
  .decided_o  (decided_o)
);

// File: tb/uart_autobaud_bench.sv
module uart_autobaud_bench;
  localparam int B_CLK   = 1_152_000;
  localparam int B_SLOW  = 3840;
  localparam int B_LIMIT = B_SLOW + B_SLOW / 50;
  localparam int B_CW    = $clog2(B_LIMIT + 2);
  localparam int B_IW    = 4;
  localparam int NV      = 19;

  // width of the low pulse, expected entry (-1: no lock)
  localparam int V_W   [NV] = '{10, 9, 20, 21, 30, 60, 59, 61, 58, 62, 120, 122, 123, 240, 480, 960, 1920, 3840, 45};
  localparam int V_IDX [NV] = '{ 9, -1, 8, -1, 7, 6, 6, 6, -1, -1, 5, 5, -1, 4, 3, 2, 1, 0, -1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rearm = 1'b0;
  logic line = 1'b1;
  logic [B_CW-1:0] divisor;
  logic [B_IW-1:0] rate_idx;
  logic locked, error, decided;

  int nvec = 0;
  int nfail = 0;
  int dcnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_autobaud #(.CLK_HZ(B_CLK), .TOL_DIV(50)) u_uart_autobaud (
    .clk_i      (clk),
    .rst_i      (rst),
    .rearm_i    (rearm),
    .line_i     (line),
    .divisor_o  (divisor),
    .rate_idx_o (rate_idx),
    .locked_o   (locked),
    .error_o    (error),
    .decided_o  (decided)
  );

  always @(posedge clk) begin
    if (rst) dcnt <= 0;
    else if (decided) dcnt <= dcnt + 1;
  end

  function automatic int bench_period(int idx);
    int r;
    r = (idx == 9) ? 115200 : (idx == 8) ? 57600 : 300 * (1 << idx);
    return B_CLK / r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_rearm();
    @(negedge clk) rearm = 1'b1;
    @(negedge clk) rearm = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse(input int w);
    @(negedge clk) line = 1'b0;
    repeat (w) @(negedge clk);
    line = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic expect_lock(input int idx, input int d0, input string req);
    check(locked === 1'b1, {req, " locked"}, locked, 1);
    check(error === 1'b0, {req, " error"}, error, 0);
    check(int'(rate_idx) == idx, {req, " rate_idx"}, rate_idx, idx);
    check(int'(divisor) == bench_period(idx), "R3 divisor", divisor, bench_period(idx));
    check(dcnt - d0 == 1, "R6 strobe count", dcnt - d0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    int d0;
    repeat (3) @(negedge clk);
    // R1 reset state, during reset and one cycle after
    check(!locked && !error && !decided && divisor == 0 && rate_idx == 0, "R1 reset", locked, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!locked && !error && !decided && divisor == 0 && rate_idx == 0, "R1 after reset", error, 0);
    repeat (3) @(negedge clk);

    // Vector table: R2 match windows, R4 rejects
    for (int v = 0; v < NV; v++) begin
      do_rearm();
      d0 = dcnt;
      pulse(V_W[v]);
      if (V_IDX[v] >= 0) begin
        expect_lock(V_IDX[v], d0, "R2");
      end else begin
        check(locked === 1'b0, "R4 no lock", locked, 0);
        check(error === 1'b0, "R4 no error", error, 0);
        check(dcnt == d0, "R4 no strobe", dcnt - d0, 0);
      end
    end

    // R4: after a reject, the next pulse is measured without re-arm
    do_rearm();
    d0 = dcnt;
    pulse(45);
    pulse(60);
    expect_lock(6, d0, "R4 recover");

    // R7: a further pulse after lock is ignored
    d0 = dcnt;
    pulse(10);
    check(locked === 1'b1 && int'(rate_idx) == 6, "R7 lock held", rate_idx, 6);
    check(int'(divisor) == bench_period(6), "R7 divisor held", divisor, bench_period(6));
    check(dcnt == d0, "R7 no strobe", dcnt - d0, 0);

    // R9: decision lands on the third edge after the line is sampled high
    do_rearm();
    d0 = dcnt;
    @(negedge clk) line = 1'b0;
    repeat (30) @(negedge clk);
    line = 1'b1;
    repeat (2) @(negedge clk);
    check(locked === 1'b0, "R9 not yet", locked, 0);
    @(negedge clk);
    check(locked === 1'b1 && decided === 1'b1, "R9 latency", locked, 1);
    repeat (3) @(negedge clk);

    // R5: limit exactly locks to entry 0, one more is an error
    do_rearm();
    d0 = dcnt;
    pulse(B_LIMIT);
    expect_lock(0, d0, "R5 at limit");
    do_rearm();
    d0 = dcnt;
    pulse(B_LIMIT + 1);
    check(error === 1'b1, "R5 error", error, 1);
    check(locked === 1'b0, "R5 no lock", locked, 0);
    check(dcnt - d0 == 1, "R6 error strobe", dcnt - d0, 1);

    // R7: pulses ignored while in error
    d0 = dcnt;
    pulse(60);
    check(error === 1'b1 && locked === 1'b0, "R7 error held", locked, 0);
    check(dcnt == d0, "R7 error no strobe", dcnt - d0, 0);

    // R8: re-arm clears the error on the next clock
    @(negedge clk) rearm = 1'b1;
    @(negedge clk) rearm = 1'b0;
    check(error === 1'b0 && locked === 1'b0, "R8 clear", error, 0);

    // R8: a line already low during re-arm is not measured
    d0 = dcnt;
    @(negedge clk) line = 1'b0;
    repeat (5) @(negedge clk);
    rearm = 1'b1;
    @(negedge clk) rearm = 1'b0;
    repeat (55) @(negedge clk);
    line = 1'b1;
    repeat (6) @(negedge clk);
    check(locked === 1'b0 && error === 1'b0, "R8 low ignored", locked, 0);
    check(dcnt == d0, "R8 no strobe", dcnt - d0, 0);
    d0 = dcnt;
    pulse(30);
    expect_lock(7, d0, "R8 next pulse");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule